// File: doc/BRIEF.md
# Eight-Bit Timer with Shared Prescaler

This block is an 8-bit timer/counter with one power-of-two prescaler. Software assigns that prescaler either to the timer or to the watchdog tick path. The timer counts either a per-cycle instruction-clock enable or edges of an external pin, and the pin passes through a synchroniser first. A control word selects the count source, the pin edge, the prescaler assignment and a 3-bit rate. The same rate code gives the timer twice the division it gives the watchdog.

Software can write the count register directly. A write empties the prescaler and holds the counter still for two cycles. When the count wraps from its top value to zero it raises a sticky overflow flag, and only an explicit clear pulse drops that flag. A watchdog base tick comes in and a watchdog tick goes out. The watchdog tick is the base tick divided by the prescaler when the prescaler belongs to the watchdog, and the base tick passed straight through otherwise. A watchdog clear input empties the prescaler while the watchdog owns it.

Top module: `tmr8_shared_div`

## Requirements
- R1: After reset `count` is 0, `ovf_flag` is 0, `wdt_tick` is 0 and the control word `ctl_q` reads all ones (6'h3F).
- R2: The control word is loaded from `ctl_wdata` on a clock edge where `ctl_wr` is 1 and reads back unchanged on `ctl_q`. Its fields are: bit 5 = source (1 external pin, 0 `instr_en`), bit 4 = edge (1 falling, 0 rising), bit 3 = assignment (1 watchdog, 0 timer), bits 2:0 = rate. A control write also empties the prescaler.
- R3: With bit 3 at 0, the count advances once per 2^(rate+1) source events, so codes 0 to 7 divide by 2 to 256. The count never moves by more than one per cycle.
- R4: With bit 3 at 1, the count advances on every source event, and `wdt_tick` pulses once per 2^rate `wdt_base` pulses. The pulse appears on the clock edge that samples the completing base pulse.
- R5: With bit 3 at 0, every `wdt_base` pulse appears on `wdt_tick` at the next clock edge.
- R6: `ext_pin` passes through two flops before edge detection. The count changes at the second rising clock edge after the edge that first samples the new pin level. Only the edge selected by bit 4 counts, and the pin has no effect while bit 5 is 0.
- R7: A clock edge with `cnt_wr` at 1 loads `cnt_wdata` into `count`. The next two edges cannot advance the count. When bit 3 is 0 the write also empties the prescaler.
- R8: An advance from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until an edge with `ovf_clr` at 1 arrives. A set and a clear on the same edge leave it set.
- R9: While bit 3 is 1, `wdt_clr` empties the prescaler, so a partial count of base pulses is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Load the control word |
| ctl_wdata | input | 6 | Control word to load |
| ctl_q | output | 6 | Current control word |
| cnt_wr | input | 1 | Load the count register |
| cnt_wdata | input | 8 | Count value to load |
| count | output | 8 | Current count |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| instr_en | input | 1 | Instruction-clock event, one per enabled cycle |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_base | input | 1 | Watchdog base tick |
| wdt_clr | input | 1 | Watchdog clear, empties prescaler when assigned |
| wdt_tick | output | 1 | Watchdog tick after optional division |

## Verification
The count, the flag and the watchdog tick follow an internal event one edge later. A count write lands one edge later, and the next increment waits for the third edge after the write. A pin change reaches the count on the third edge after the pin moves, because it first crosses the two synchroniser flops. The bench drives inputs just after a rising edge and reads outputs just after the next one, so each check names the exact edge where a result is due. The bench also checks the value one edge before that edge for the write hold and the pin latency.

// File: rtl/tmr8_pkg.sv
// Shared types for the 8-bit timer with shared prescaler.
// Assumes a 3-bit rate code; the control word packs source, edge,
// assignment and rate from most to least significant bit.
package tmr8_pkg;
    localparam int RATE_W = 3;
    localparam int CTL_W  = RATE_W + 3;

    typedef struct packed {
        logic               src_pin;     // 1: external pin, 0: instruction enable
        logic               fall_edge;   // 1: count falling pin edges
        logic               div_to_wdt;  // 1: prescaler serves the watchdog
        logic [RATE_W-1:0]  rate;        // power-of-two rate code
    } tmr_ctl_t;

    localparam tmr_ctl_t CTL_RESET = '1;
endpackage

// File: rtl/tmr8_pinsync.sv
// Synchronises an asynchronous pin through STAGES flops and produces
// single-cycle rise and fall pulses from the synchronised level.
// Assumes STAGES >= 2.
module tmr8_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw pin into the synchroniser chain and keep the prior level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Detect level changes of the synchronised pin.
    always_comb begin
        rise_o = sync_q[STAGES-1] & ~last_q;
        fall_o = ~sync_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/tmr8_prescale.sv
// Power-of-two prescaler shared between timer and watchdog paths.
// The division exponent is rate+1 when serving the timer and rate
// when serving the watchdog; an exponent of zero passes every event.
// Assumes PRE_W equals 2**RATE_W so the largest exponent fits.
module tmr8_prescale #(
    parameter int RATE_W = 3,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ev_i,
    input  logic              to_wdt_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              fire_o
);
    localparam int EXP_W = RATE_W + 1;

    logic [PRE_W-1:0] acc_q;
    logic [PRE_W-1:0] mask;
    logic [EXP_W-1:0] exp_w;

    // Pick the division exponent from the assignment.
    always_comb begin
        exp_w = {1'b0, rate_i} + (to_wdt_i ? EXP_W'(0) : EXP_W'(1));
    end

    // One mask bit per prescaler stage below the exponent.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (exp_w > EXP_W'(i));
    end

    // Fire on the event that completes a full division period.
    always_comb begin
        fire_o = ev_i && ((acc_q & mask) == mask);
    end

    // Count events, emptying on a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
        end else if (ev_i) begin
            acc_q <= acc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr8_core.sv
// Count register with write load, post-write increment hold and a
// sticky overflow flag. A write takes priority over an increment and
// suppresses the overflow for that edge.
module tmr8_core #(
    parameter int CNT_W    = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             inc_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              flag_q;
    logic              step;

    // An increment is taken only outside the post-write hold window.
    always_comb begin
        step = inc_i && (hold_q == '0) && !wr_i;
    end

    // Load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            cnt_q <= wdata_i;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Arm the hold window on a write and drain it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_i) begin
            hold_q <= HOLD_W'(HOLD_CYC);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Set the flag on wrap; a wrap beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (step && (cnt_q == '1)) begin
            flag_q <= 1'b1;
        end else if (flag_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign count_o = cnt_q;
    assign flag_o  = flag_q;
endmodule

// File: rtl/tmr8_shared_div.sv
// Top of the 8-bit timer with a prescaler shared with the watchdog path.
// Holds the control word, routes events to and from the prescaler and
// registers the watchdog tick. Assumes instr_en and wdt_base are
// synchronous single-cycle event strobes.
module tmr8_shared_div
    import tmr8_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SYNC_STG = 2,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    input  logic             instr_en,
    input  logic             ext_pin,
    input  logic             wdt_base,
    input  logic             wdt_clr,
    output logic             wdt_tick
);
    localparam int PRE_W = 1 << RATE_W;

    tmr_ctl_t ctl_r;
    logic     pin_rise, pin_fall;
    logic     src_ev, pre_ev, pre_fire, pre_clr;
    logic     tmr_inc, wdt_src, tick_q;

    // Control word register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r <= CTL_RESET;
        end else if (ctl_wr) begin
            ctl_r <= tmr_ctl_t'(ctl_wdata);
        end
    end

    tmr8_pinsync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    // Route the source, prescaler input and outputs by assignment.
    always_comb begin
        src_ev  = ctl_r.src_pin ? (ctl_r.fall_edge ? pin_fall : pin_rise) : instr_en;
        pre_ev  = ctl_r.div_to_wdt ? wdt_base : src_ev;
        tmr_inc = ctl_r.div_to_wdt ? src_ev : pre_fire;
        wdt_src = ctl_r.div_to_wdt ? pre_fire : wdt_base;
        pre_clr = ctl_wr
                | (cnt_wr && !ctl_r.div_to_wdt)
                | (wdt_clr && ctl_r.div_to_wdt);
    end

    tmr8_prescale #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (pre_clr),
        .ev_i     (pre_ev),
        .to_wdt_i (ctl_r.div_to_wdt),
        .rate_i   (ctl_r.rate),
        .fire_o   (pre_fire)
    );

    tmr8_core #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cnt_wr),
        .wdata_i    (cnt_wdata),
        .inc_i      (tmr_inc),
        .flag_clr_i (ovf_clr),
        .count_o    (count),
        .flag_o     (ovf_flag)
    );

    // Register the watchdog tick so it leaves as a clean pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= wdt_src;
        end
    end

    assign wdt_tick = tick_q;
    assign ctl_q    = ctl_r;
endmodule

// File: rtl/tmr8_chk.sv
// Property checker for tmr8_shared_div, attached by bind below.
// Observes ports only.
module tmr8_chk
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CTL_W-1:0] ctl_q,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] count,
    input logic             ovf_clr,
    input logic             ovf_flag,
    input logic             wdt_base,
    input logic             wdt_tick
);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    // R8
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0) && ($past(count) == '1));

    // R7
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count == $past(cnt_wdata));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr) && !cnt_wr |=> $stable(count));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R5
    wdt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[RATE_W] && wdt_base |=> wdt_tick);

    // R4
    wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[RATE_W] && !wdt_base |=> !wdt_tick);
endmodule

bind tmr8_shared_div tmr8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_q     (ctl_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .count     (count),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag),
    .wdt_base  (wdt_base),
    .wdt_tick  (wdt_tick)
);

// File: tb/tmr8_shared_div_bench.sv
module tmr8_shared_div_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {control[29:24], event count[23:8], expected count[7:0]}
    localparam logic [29:0] VEC [NVEC] = '{
        {6'h00, 16'd10,  8'd5},   // R3 rate 0, divide by 2
        {6'h02, 16'd40,  8'd5},   // R3 rate 2, divide by 8
        {6'h07, 16'd600, 8'd2},   // R3 rate 7, divide by 256
        {6'h03, 16'd15,  8'd0},   // R3 one short of a period
        {6'h03, 16'd16,  8'd1},   // R3 exactly one period
        {6'h0D, 16'd37,  8'd37},  // R4 timer at 1:1
        {6'h08, 16'd300, 8'd44}   // R4 1:1 with wrap
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [5:0] ctl_q;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] count;
    logic       ovf_clr = 1'b0;
    logic       ovf_flag;
    logic       instr_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_base = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       wdt_tick;

    int total = 0;
    int bad = 0;
    int ticks = 0;

    tmr8_shared_div u_tmr8_shared_div (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .count(count),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .instr_en(instr_en),
        .ext_pin(ext_pin), .wdt_base(wdt_base), .wdt_clr(wdt_clr),
        .wdt_tick(wdt_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
        if (wdt_tick) ticks++;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        step();
        cnt_wr = 1'b0;
        step();
        step();
    endtask

    task automatic run_ev(input int n);
        instr_en = 1'b1;
        for (int k = 0; k < n; k++) step();
        instr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 tick", wdt_tick, 0);
        chk("R1 ctl", ctl_q, 6'h3F);
        rst_n = 1'b1;
        step();

        // Table walk: R2 readback, R3/R4 division ratios
        for (int i = 0; i < NVEC; i++) begin
            wr_ctl(VEC[i][29:24]);
            chk("R2 ctl readback", ctl_q, VEC[i][29:24]);
            wr_cnt(8'h00);
            run_ev(int'(VEC[i][23:8]));
            chk(i < 5 ? "R3 ratio" : "R4 timer 1:1", count, VEC[i][7:0]);
        end

        // R6 rising edge through the synchroniser
        wr_ctl(6'h28);
        wr_cnt(8'h00);
        ext_pin = 1'b1;
        step(); step();
        chk("R6 before latency", count, 0);
        step();
        chk("R6 rise counted", count, 1);
        ext_pin = 1'b0;
        repeat (4) step();
        chk("R6 fall ignored", count, 1);
        wr_ctl(6'h38);
        ext_pin = 1'b1;
        repeat (4) step();
        chk("R6 rise ignored", count, 1);
        ext_pin = 1'b0;
        repeat (3) step();
        chk("R6 fall counted", count, 2);

        // R6 pin has no effect on internal source
        wr_ctl(6'h08);
        for (int k = 0; k < 4; k++) begin
            ext_pin = ~ext_pin;
            repeat (3) step();
        end
        chk("R6 pin ignored", count, 2);

        // R7 write hold with continuous events
        instr_en = 1'b1;
        cnt_wr = 1'b1; cnt_wdata = 8'h10;
        step();
        cnt_wr = 1'b0;
        chk("R7 load", count, 8'h10);
        step();
        chk("R7 hold 1", count, 8'h10);
        step();
        chk("R7 hold 2", count, 8'h10);
        step();
        chk("R7 resume", count, 8'h11);
        instr_en = 1'b0;

        // R7 write empties the timer prescaler
        wr_ctl(6'h01);
        wr_cnt(8'h00);
        run_ev(3);
        chk("R7 partial", count, 0);
        wr_cnt(8'h00);
        run_ev(3);
        chk("R7 prescaler cleared", count, 0);
        run_ev(1);
        chk("R7 period done", count, 1);

        // R8 overflow flag
        wr_ctl(6'h08);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk("R8 cleared", ovf_flag, 0);
        wr_cnt(8'hFE);
        run_ev(1);
        chk("R8 no flag at FF", ovf_flag, 0);
        run_ev(1);
        chk("R8 wrap count", count, 0);
        chk("R8 wrap flag", ovf_flag, 1);
        run_ev(5);
        chk("R8 sticky", ovf_flag, 1);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk("R8 clear", ovf_flag, 0);
        wr_cnt(8'hFF);
        instr_en = 1'b1; ovf_clr = 1'b1;
        step();
        instr_en = 1'b0; ovf_clr = 1'b0;
        chk("R8 set beats clear", ovf_flag, 1);
        chk("R8 set beats clear count", count, 0);

        // R4 watchdog division by 4
        wr_ctl(6'h0A);
        ticks = 0;
        wdt_base = 1'b1;
        repeat (3) step();
        chk("R4 no tick yet", ticks, 0);
        step();
        chk("R4 first tick", ticks, 1);
        repeat (4) step();
        wdt_base = 1'b0;
        step();
        chk("R4 two ticks", ticks, 2);

        // R9 watchdog clear empties prescaler
        wdt_base = 1'b1; repeat (3) step(); wdt_base = 1'b0;
        wdt_clr = 1'b1; step(); wdt_clr = 1'b0;
        wdt_base = 1'b1; repeat (3) step(); wdt_base = 1'b0;
        step();
        chk("R9 partial lost", ticks, 2);
        wdt_base = 1'b1; step(); wdt_base = 1'b0;
        step();
        chk("R9 period done", ticks, 3);

        // R5 pass-through while prescaler serves timer
        wr_ctl(6'h07);
        ticks = 0;
        wdt_base = 1'b1; repeat (5) step(); wdt_base = 1'b0;
        step();
        chk("R5 pass-through", ticks, 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule